// File: doc/BRIEF.md
# Interrupt and Subroutine Stack Sequencer

This block drives the byte-wide hardware stack of an 8-bit processor that has a 16-bit address space. It holds the stack pointer, which always names the next free byte, and it turns each stack request into a run of single-byte accesses on a memory port. There are six operations: push one byte, pull one byte, call, return, interrupt entry and interrupt exit. Call saves a 16-bit return address. Interrupt entry saves the whole register set, and interrupt exit restores it.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. All request fields (kind, byte, return address, register values, the non-maskable flag) are sampled on that accepting edge alone, so the source may change them on the next cycle. The block applies no back-pressure within a sequence. Its memory port has no stall, and `mem_rdata` must be valid in the same cycle as the read it answers.

When a request finishes, `done` pulses. The values pulled from the stack, or after an entry the saved registers with the mask bits set, appear on the `out_*` pins. After an entry, `vec_req` asks the surrounding core to fetch the vector.

Top module: `stk_engine`

## Requirements
- R1: After reset the pointer equals the parameter SP_RESET (default 16'h00FF), `req_ready` is 1, and `busy`, `done`, `vec_req` and `mem_en` are 0.
- R2: A push (req_kind 0) writes the byte at the current pointer and then decrements the pointer by one.
- R3: A pull (req_kind 1) first increments the pointer, then reads at the new pointer, and presents the byte on `out_byte`.
- R4: A call (req_kind 2) pushes `req_ret`, low byte first, so the pointer drops by two. A return (req_kind 3) pulls two bytes and presents the rebuilt address on `out_pc`.
- R5: Interrupt entry (req_kind 4) pushes nine bytes at falling addresses in this order: PC low, PC high, IY low, IY high, IX low, IX high, A, B, CCR. The pointer ends nine below its start.
- R6: The CCR byte written to the stack is the unmodified input value. When entry completes, `out_ccr` has I (bit 4) set, and also X (bit 6) when `req_xint` was 1. `vec_req` pulses together with `done` for entries only.
- R7: Interrupt exit (req_kind 5) pulls nine bytes, CCR first, in exactly the reverse of entry order. It restores every register to the value that was saved, including an unmasked CCR.
- R8: From acceptance until `done`, `busy` is 1 and `req_ready` is 0. Any request offered in that time is ignored and does not move the pointer.
- R9: `done` is a one-cycle pulse in the cycle after a request's last memory access. The latency from the accepting edge to `done` is the byte count plus one: 2, 3 or 10 cycles.
- R10: Pointer arithmetic wraps at 16 bits. A push at 16'h0000 leaves 16'hFFFF, and a pull from 16'hFFFF reads address 16'h0000.
- R11: `sp_load` replaces the pointer with `sp_load_val` when the block is not busy, and has no effect while busy.
- R12: req_kind codes 6 and 7 are accepted by the handshake and then dropped. No memory access, no `done` and no pointer change follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 3 | 0 push, 1 pull, 2 call, 3 return, 4 entry, 5 exit |
| req_xint | input | 1 | Entry is for the non-maskable line (sets X too) |
| req_byte | input | 8 | Byte to push |
| req_ret | input | 16 | Return address for a call |
| cpu_pc | input | 16 | Program counter saved on entry |
| cpu_iy | input | 16 | Index Y saved on entry |
| cpu_ix | input | 16 | Index X saved on entry |
| cpu_a | input | 8 | Accumulator A saved on entry |
| cpu_b | input | 8 | Accumulator B saved on entry |
| cpu_ccr | input | 8 | Condition codes saved on entry |
| sp_load | input | 1 | Load the pointer when idle |
| sp_load_val | input | 16 | Value to load |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the access cycle |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Request finished (pulse) |
| vec_req | output | 1 | Vector fetch request after entry (pulse) |
| out_byte | output | 8 | Byte from the last pull |
| out_pc | output | 16 | Return address or restored PC |
| out_iy | output | 16 | Restored IY |
| out_ix | output | 16 | Restored IX |
| out_a | output | 8 | Restored A |
| out_b | output | 8 | Restored B |
| out_ccr | output | 8 | Restored CCR, or masked CCR after entry |

## Verification
The properties assume that memory answers a read in the same cycle with no wait state. They also assume that `rst_n` is held low for at least one edge before the first request. The bench meets the first assumption with a zero-latency byte array that is indexed by the low eight address bits. This works because every stack region it uses, including the region around the 16-bit wrap, falls on distinct low bytes. Requests are offered only at falling edges and dropped after one accepting edge. The exception is the deliberate overlap test, which holds `req_valid` high while a sequence is running.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FRAME_B    = 9;
  localparam int unsigned FRAME_W    = FRAME_B * BYTE_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_B + 1);
  localparam int unsigned CCR_I_POS  = 4;
  localparam int unsigned CCR_X_POS  = 6;

  localparam logic [2:0] OP_PUSH = 3'd0;
  localparam logic [2:0] OP_PULL = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_IENT = 3'd4;
  localparam logic [2:0] OP_IEXT = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_e;

  function automatic logic op_known(input logic [2:0] k);
    return k <= OP_IEXT;
  endfunction

  function automatic logic op_reads(input logic [2:0] k);
    return (k == OP_PULL) || (k == OP_RET) || (k == OP_IEXT);
  endfunction

  function automatic logic [CNT_W-1:0] op_len(input logic [2:0] k);
    case (k)
      OP_CALL, OP_RET:  return CNT_W'(2);
      OP_IENT, OP_IEXT: return CNT_W'(FRAME_B);
      default:          return CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] SP_RESET = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  logic          step_up,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_up
);
  assign sp_up = sp_q + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= SP_RESET;
    else if (step_en) sp_q <= step_up ? sp_up : sp_q - AW'(1);
    else if (load_en) sp_q <= load_val;
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic             req_xint,
  output logic             req_ready,
  output logic             start,
  output logic             busy,
  output logic             acc_en,
  output logic             acc_rd,
  output logic             acc_last,
  output logic [CNT_W-1:0] slot,
  output logic [2:0]       kind_q,
  output logic             xint_q,
  output logic             done,
  output logic             vec_req
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] step_q, len_q;

  assign req_ready = (state_q == ST_IDLE);
  assign start     = req_valid && req_ready && op_known(req_kind);
  assign busy      = (state_q != ST_IDLE);
  assign acc_en    = (state_q == ST_RUN);
  assign acc_rd    = op_reads(kind_q);
  assign acc_last  = acc_en && (step_q == len_q - CNT_W'(1));
  assign slot      = acc_rd ? (len_q - CNT_W'(1) - step_q) : step_q;
  assign done      = (state_q == ST_FIN);
  assign vec_req   = done && (kind_q == OP_IENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      len_q   <= '0;
      kind_q  <= OP_PUSH;
      xint_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          step_q  <= '0;
          len_q   <= op_len(req_kind);
          kind_q  <= req_kind;
          xint_q  <= req_xint;
        end
        ST_RUN: begin
          if (acc_last) state_q <= ST_FIN;
          else          step_q  <= step_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_frame.sv
module stk_frame
  import stk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic [2:0]         cap_kind,
  input  logic [7:0]         cap_byte,
  input  logic [15:0]        cap_ret,
  input  logic [15:0]        cap_pc,
  input  logic [15:0]        cap_iy,
  input  logic [15:0]        cap_ix,
  input  logic [7:0]         cap_a,
  input  logic [7:0]         cap_b,
  input  logic [7:0]         cap_ccr,
  input  logic [CNT_W-1:0]   slot,
  input  logic               rd_en,
  input  logic [7:0]         rd_data,
  input  logic               mask_en,
  input  logic               mask_x,
  output logic [7:0]         wr_byte,
  output logic [FRAME_W-1:0] res_q
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] masked;

  assign wr_byte = frame_q[{slot, 3'b000} +: BYTE_W];

  always_comb begin
    masked = frame_q;
    masked[FRAME_W - BYTE_W + CCR_I_POS] = 1'b1;
    if (mask_x) masked[FRAME_W - BYTE_W + CCR_X_POS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else if (cap) begin
      case (cap_kind)
        OP_IENT: frame_q <= {cap_ccr, cap_b, cap_a, cap_ix, cap_iy, cap_pc};
        OP_CALL: frame_q <= {(FRAME_W-16)'(0), cap_ret};
        default: frame_q <= {(FRAME_W-8)'(0), cap_byte};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (mask_en) res_q <= masked;
    else if (rd_en) begin
      for (int k = 0; k < FRAME_B; k++)
        if (slot == CNT_W'(k)) res_q[k*BYTE_W +: BYTE_W] <= rd_data;
    end
  end
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter logic [15:0] SP_RESET = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_kind,
  input  logic        req_xint,
  input  logic [7:0]  req_byte,
  input  logic [15:0] req_ret,
  input  logic [15:0] cpu_pc,
  input  logic [15:0] cpu_iy,
  input  logic [15:0] cpu_ix,
  input  logic [7:0]  cpu_a,
  input  logic [7:0]  cpu_b,
  input  logic [7:0]  cpu_ccr,
  input  logic        sp_load,
  input  logic [15:0] sp_load_val,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] sp,
  output logic        busy,
  output logic        done,
  output logic        vec_req,
  output logic [7:0]  out_byte,
  output logic [15:0] out_pc,
  output logic [15:0] out_iy,
  output logic [15:0] out_ix,
  output logic [7:0]  out_a,
  output logic [7:0]  out_b,
  output logic [7:0]  out_ccr
);
  logic             start, acc_en, acc_rd, acc_last, xint_q;
  logic [CNT_W-1:0] slot;
  logic [2:0]       kind_q;
  logic [15:0]      sp_up;
  logic [FRAME_W-1:0] res;

  stk_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .req_kind, .req_xint, .req_ready,
    .start, .busy, .acc_en, .acc_rd, .acc_last, .slot,
    .kind_q, .xint_q, .done, .vec_req
  );

  stk_ptr #(.AW(16), .SP_RESET(SP_RESET)) u_ptr (
    .clk, .rst_n,
    .load_en (sp_load && !busy),
    .load_val(sp_load_val),
    .step_en (acc_en),
    .step_up (acc_rd),
    .sp_q    (sp),
    .sp_up   (sp_up)
  );

  stk_frame u_frame (
    .clk, .rst_n,
    .cap     (start),
    .cap_kind(req_kind),
    .cap_byte(req_byte),
    .cap_ret (req_ret),
    .cap_pc  (cpu_pc),
    .cap_iy  (cpu_iy),
    .cap_ix  (cpu_ix),
    .cap_a   (cpu_a),
    .cap_b   (cpu_b),
    .cap_ccr (cpu_ccr),
    .slot,
    .rd_en   (acc_en && acc_rd),
    .rd_data (mem_rdata),
    .mask_en (acc_last && (kind_q == OP_IENT)),
    .mask_x  (xint_q),
    .wr_byte (mem_wdata),
    .res_q   (res)
  );

  assign mem_en   = acc_en;
  assign mem_we   = acc_en && !acc_rd;
  assign mem_addr = acc_rd ? sp_up : sp;

  assign out_byte = res[7:0];
  assign out_pc   = res[15:0];
  assign out_iy   = res[31:16];
  assign out_ix   = res[47:32];
  assign out_a    = res[55:48];
  assign out_b    = res[63:56];
  assign out_ccr  = res[71:64];
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_en,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] sp,
  input logic        busy,
  input logic        done,
  input logic        vec_req,
  input logic [7:0]  out_ccr
);
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we |=> sp == $past(mem_addr) - 16'd1); // R2
  AST_PULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !mem_we |=> sp == $past(mem_addr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en && !done); // R8
  AST_IDLE_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_en |=> sp == $past(sp)); // R8
  AST_VEC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> done); // R6
  AST_MASK_AT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> out_ccr[4]); // R6
endmodule

bind stk_engine stk_engine_chk u_chk (.*);

// File: tb/tb_stk_engine.sv
module tb_stk_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_xint = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [7:0]  req_byte = '0;
  logic [15:0] req_ret = '0, cpu_pc = '0, cpu_iy = '0, cpu_ix = '0;
  logic [7:0]  cpu_a = '0, cpu_b = '0, cpu_ccr = '0;
  logic        sp_load = 1'b0;
  logic [15:0] sp_load_val = '0;
  logic        mem_en, mem_we, busy, done, vec_req;
  logic [15:0] mem_addr, sp, out_pc, out_iy, out_ix;
  logic [7:0]  mem_wdata, mem_rdata, out_byte, out_a, out_b, out_ccr;
  logic [7:0]  mem [256];

  int checks = 0, failures = 0, lat = 0;
  logic vec_seen = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_engine dut (.*);

  assign mem_rdata = mem[mem_addr[7:0]];
  always_ff @(posedge clk) if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  // vector: kind[51:49] arg[48:33] exp_sp[32:17] exp_res[16:1] chk_res[0]
  localparam int NV = 6;
  localparam logic [51:0] VEC [NV] = '{
    {3'd0, 16'h00A5, 16'h007F, 16'h0000, 1'b0},
    {3'd0, 16'h003C, 16'h007E, 16'h0000, 1'b0},
    {3'd1, 16'h0000, 16'h007F, 16'h003C, 1'b1},
    {3'd2, 16'h1234, 16'h007D, 16'h0000, 1'b0},
    {3'd3, 16'h0000, 16'h007F, 16'h1234, 1'b1},
    {3'd1, 16'h0000, 16'h0080, 16'h00A5, 1'b1}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] k, input logic x);
    @(negedge clk);
    req_kind = k; req_xint = x; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; vec_seen = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    vec_seen = vec_req;
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    @(negedge clk);
    sp_load = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] base;
    logic [7:0]  exp_b [9];
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sp == 16'h00FF, "R1 sp reset", sp, 16'h00FF);
    check(req_ready && !busy && !done && !vec_req && !mem_en, "R1 idle outputs",
          {req_ready, busy, done, vec_req, mem_en}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 load, then table walk
    load_sp(16'h0080);
    check(sp == 16'h0080, "R11 sp load", sp, 16'h0080);
    for (int i = 0; i < NV; i++) begin
      req_byte = VEC[i][40:33];
      req_ret  = VEC[i][48:33];
      run_req(VEC[i][51:49], 1'b0);
      check(sp == VEC[i][32:17], "R2/R3/R4 table sp", sp, VEC[i][32:17]);
      if (VEC[i][0])
        check((VEC[i][51:49] == 3'd3 ? out_pc : {8'h00, out_byte}) == VEC[i][16:1],
              "R3/R4 table result",
              VEC[i][51:49] == 3'd3 ? out_pc : {8'h00, out_byte}, VEC[i][16:1]);
    end
    check(mem[8'h7F] == 8'h34 && mem[8'h7E] == 8'h12, "R4 call low byte first",
          {mem[8'h7F], mem[8'h7E]}, 16'h3412);

    // R9 latency
    req_byte = 8'h11;
    run_req(3'd0, 1'b0);
    check(lat == 2, "R9 push latency", lat, 2);
    run_req(3'd1, 1'b0);

    // R5 / R6 entry
    cpu_pc = 16'hC123; cpu_iy = 16'h4567; cpu_ix = 16'h89AB;
    cpu_a = 8'h5A; cpu_b = 8'hB6; cpu_ccr = 8'h01;
    base = sp;
    run_req(3'd4, 1'b0);
    check(lat == 10, "R9 entry latency", lat, 10);
    check(sp == base - 16'd9, "R5 entry sp", sp, base - 16'd9);
    exp_b = '{8'h23, 8'hC1, 8'h67, 8'h45, 8'hAB, 8'h89, 8'h5A, 8'hB6, 8'h01};
    for (int k = 0; k < 9; k++)
      check(mem[8'(base - 16'(k))] == exp_b[k], "R5 entry byte order",
            mem[8'(base - 16'(k))], exp_b[k]);
    check(vec_seen, "R6 vec_req with done", vec_seen, 1);
    check(out_ccr == 8'h11, "R6 I set, X clear", out_ccr, 8'h11);

    // R7 exit with different live inputs
    cpu_pc = 16'h0000; cpu_ccr = 8'hFF;
    run_req(3'd5, 1'b0);
    check(sp == base, "R7 exit sp", sp, base);
    check(out_pc == 16'hC123 && out_iy == 16'h4567 && out_ix == 16'h89AB,
          "R7 restored index/pc", {out_iy, out_pc}, 32'h4567C123);
    check(out_a == 8'h5A && out_b == 8'hB6 && out_ccr == 8'h01, "R7 restored a/b/ccr",
          {out_a, out_b, out_ccr}, 24'h5AB601);
    check(!vec_seen, "R6 no vec on exit", vec_seen, 0);

    // R6 non-maskable entry sets X and I
    cpu_ccr = 8'h00;
    run_req(3'd4, 1'b1);
    check(out_ccr == 8'h50, "R6 X and I set", out_ccr, 8'h50);
    check(mem[8'(base - 16'd8)] == 8'h00, "R6 stacked ccr unmasked", mem[8'(base - 16'd8)], 0);
    run_req(3'd5, 1'b0);

    // R8 overlap ignored; R11 load ignored while busy
    base = sp;
    @(negedge clk);
    req_kind = 3'd4; req_xint = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_kind = 3'd0; req_byte = 8'hEE;
    check(busy && !req_ready, "R8 busy during sequence", {busy, req_ready}, 2'b10);
    sp_load = 1'b1; sp_load_val = 16'h0010;
    repeat (3) @(negedge clk);
    req_valid = 1'b0; sp_load = 1'b0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sp == base - 16'd9, "R8/R11 requests ignored while busy", sp, base - 16'd9);
    run_req(3'd5, 1'b0);

    // R10 wrap
    load_sp(16'h0000);
    req_byte = 8'h77;
    run_req(3'd0, 1'b0);
    check(sp == 16'hFFFF && mem[8'h00] == 8'h77, "R10 push wraps", sp, 16'hFFFF);
    run_req(3'd1, 1'b0);
    check(sp == 16'h0000 && out_byte == 8'h77, "R10 pull wraps", {sp, 8'h00, out_byte}, 32'h00000077);

    // R12 unknown code dropped
    @(negedge clk);
    req_kind = 3'd6; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    repeat (4) begin
      @(negedge clk);
      if (done || mem_en) lat++;
    end
    check(lat == 0 && sp == 16'h0000 && req_ready, "R12 code 6 dropped", {lat[7:0], sp}, 0);

    finish_run();
  end
endmodule